// File: doc/BRIEF.md
# Serial Gain-Word Control Interface

This block is the digital front end of a stepped gain/attenuator. A nine-bit control word selects a coarse step, a fine step and a direction (boost or cut). In serial mode the word arrives one bit at a time on a data pin, clocked by an external shift clock, into a shift register. A separate load strobe then copies it into a holding latch, and the latch drives the active setting. A new word can therefore be staged without touching the one in use. A readback strobe copies the latch back into the shift register, so the stored word can be clocked out on a serial output pin.

In parallel mode a mode pin bypasses both registers, and nine parallel pins drive the selection directly. The selected word is decoded into a signed gain in tenths of a decibel. A coarse step is 1.5 dB and a fine step is 0.1 dB. The external shift clock, data and strobes are asynchronous to the fast system clock. They pass through a two-flop synchronizer before edge detection, so every external pulse must last at least three system clocks. A powerdown pin is only reported as a status. The serial logic and the latch keep working while it is asserted.

Top module: `gainword_ctrl`

## Requirements
- R1: Word layout: bits 3..0 hold the fine count F, bits 7..4 hold the coarse count C, and bit 8 selects the direction (1 means cut, giving a negative gain; 0 means boost).
- R2: Each synchronized rising edge of `sck_pin` shifts `sid_pin` into the shift register at bit 8 and moves the other bits down by one. After nine edges, the first bit sent sits in bit 0.
- R3: `sod` takes the shift register's bit 0 on each synchronized falling edge of `sck_pin`. It holds its value at all other times, except on an accepted readback.
- R4: The latch, and so the serial-mode `sel_word`, changes only on an accepted rising edge of `load_pin`. Shifting alone never alters it.
- R5: A rising edge of `readback_pin` while the shift clock is low copies the latch into the shift register and places latch bit 0 on `sod` at once.
- R6: A rising edge of `load_pin` or `readback_pin` while the shift clock is high is ignored and sets `proto_err`. The flag stays set until the next accepted strobe or reset.
- R7: With `serial_mode`=1, `sel_word` equals the latch. With `serial_mode`=0, `sel_word` equals `par_word`, and switching back to serial mode restores the latch value.
- R8: `gain_tenths` equals 15*C + F with boost and -(15*C + F) with cut. It spans -240..+240, and a cut with C=F=0 gives 0.
- R9: `pwr_down` does not alter the latch or stop the serial path. `pd_status` follows `pwr_down` one clock later.
- R10: Accepted load and readback edges in the same clock exchange the two registers. The latch takes the old shift contents, and the shift register takes the old latch contents, with old latch bit 0 on `sod`.
- R11: Synchronous reset clears the shift register, latch, `sod` and `proto_err`, giving a `sel_word` of 0 and a gain of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_pin | input | 1 | External shift clock (asynchronous) |
| sid_pin | input | 1 | External serial data in |
| load_pin | input | 1 | Strobe that copies the shift register into the latch |
| readback_pin | input | 1 | Strobe that copies the latch into the shift register |
| serial_mode | input | 1 | 1 selects the serial/latch path, 0 selects the parallel pins |
| pwr_down | input | 1 | Powerdown request, reported only |
| par_word | input | 9 | Parallel selection word |
| sod | output | 1 | Serial data out |
| sel_word | output | 9 | Effective selection word |
| gain_tenths | output | 10 | Signed gain in 0.1 dB units |
| proto_err | output | 1 | Sticky flag for a strobe that arrived while the shift clock was high |
| pd_status | output | 1 | Registered powerdown status |

## Verification
A load strobe and a readback strobe can be detected in the same system clock. The bench provokes this by raising both pins on the same cycle while the shift clock is low. It then judges the result through the new `sel_word` and gain, the immediate `sod` bit, and a full serial readback of the word the shift register received. A readback strobe can also coincide with a shift-clock falling edge, since both need the clock low. In that case the readback value must win on `sod`, and the checker enforces this as well.

// File: rtl/gainword_pkg.sv
package gainword_pkg;
    localparam int DEF_FINE_W      = 4;
    localparam int DEF_COARSE_W    = 4;
    localparam int DEF_COARSE_STEP = 15;
    localparam int DEF_FINE_STEP   = 1;
    localparam int DEF_GAIN_W      = 10;
    localparam int DEF_SYNC_STAGES = 2;

    // positions of the external strobes in the synchronizer vector
    localparam int PIN_SCK = 0;
    localparam int PIN_SID = 1;
    localparam int PIN_LD  = 2;
    localparam int PIN_RB  = 3;
    localparam int PIN_N   = 4;
endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[g]};
        end

        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= chain_d;
        end

        assign lvl[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/gw_edge.sv
module gw_edge #(
    parameter int           N        = 4,
    parameter logic [N-1:0] PREV_RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PREV_RST;
        else     prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise[g] = lvl[g] & ~prev_q[g];
    end
endmodule

// File: rtl/gw_shift_latch.sv
module gw_shift_latch #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_lvl,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sid_lvl,
    input  logic              ld_rise,
    input  logic              rb_rise,
    output logic [WORD_W-1:0] shift_word,
    output logic [WORD_W-1:0] latch_word,
    output logic              sod,
    output logic              proto_err
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] lat;
        logic              sod;
        logic              err;
    } sl_state_t;

    sl_state_t st_d, st_q;
    logic ld_ok, rb_ok, bad_strobe;

    always_comb begin
        st_d       = st_q;
        ld_ok      = ld_rise & ~sck_lvl;
        rb_ok      = rb_rise & ~sck_lvl;
        bad_strobe = (ld_rise | rb_rise) & sck_lvl;

        if (sck_rise) st_d.sr  = {sid_lvl, st_q.sr[WORD_W-1:1]};
        if (sck_fall) st_d.sod = st_q.sr[0];
        if (ld_ok)    st_d.lat = st_q.sr;
        if (rb_ok) begin
            st_d.sr  = st_q.lat;
            st_d.sod = st_q.lat[0];
        end

        if (bad_strobe)          st_d.err = 1'b1;
        else if (ld_ok || rb_ok) st_d.err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign shift_word = st_q.sr;
    assign latch_word = st_q.lat;
    assign sod        = st_q.sod;
    assign proto_err  = st_q.err;
endmodule

// File: rtl/gw_gain_decode.sv
module gw_gain_decode #(
    parameter int FINE_W      = 4,
    parameter int COARSE_W    = 4,
    parameter int COARSE_STEP = 15,
    parameter int FINE_STEP   = 1,
    parameter int GAIN_W      = 10
) (
    input  logic [FINE_W+COARSE_W:0]  word,
    output logic signed [GAIN_W-1:0]  gain_tenths
);
    localparam int WORD_W = FINE_W + COARSE_W + 1;

    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
    logic                cut;
    logic [GAIN_W-1:0]   mag;

    always_comb begin
        fine   = word[FINE_W-1:0];
        coarse = word[FINE_W +: COARSE_W];
        cut    = word[WORD_W-1];
        mag    = GAIN_W'(coarse) * GAIN_W'(COARSE_STEP)
               + GAIN_W'(fine)   * GAIN_W'(FINE_STEP);
        gain_tenths = cut ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/gainword_ctrl.sv
module gainword_ctrl
    import gainword_pkg::*;
#(
    parameter int FINE_W      = DEF_FINE_W,
    parameter int COARSE_W    = DEF_COARSE_W,
    parameter int COARSE_STEP = DEF_COARSE_STEP,
    parameter int FINE_STEP   = DEF_FINE_STEP,
    parameter int GAIN_W      = DEF_GAIN_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int WORD_W     = FINE_W + COARSE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sck_pin,
    input  logic                     sid_pin,
    input  logic                     load_pin,
    input  logic                     readback_pin,
    input  logic                     serial_mode,
    input  logic                     pwr_down,
    input  logic [WORD_W-1:0]        par_word,
    output logic                     sod,
    output logic [WORD_W-1:0]        sel_word,
    output logic signed [GAIN_W-1:0] gain_tenths,
    output logic                     proto_err,
    output logic                     pd_status
);
    // edge vector: 0 sck rise, 1 sck fall (rise of inverted level), 2 load, 3 readback
    localparam int EDGE_N = 4;
    localparam logic [EDGE_N-1:0] EDGE_PREV_RST = 4'b0010;

    typedef struct packed {
        logic pd;
    } top_state_t;

    logic [PIN_N-1:0]  pins, lvl;
    logic [EDGE_N-1:0] edge_in, rise;
    logic              sck_lvl, sck_rise, sck_fall, ld_rise, rb_rise;
    logic [WORD_W-1:0] shift_word, latch_word;
    top_state_t        top_d, top_q;

    always_comb begin
        pins          = '0;
        pins[PIN_SCK] = sck_pin;
        pins[PIN_SID] = sid_pin;
        pins[PIN_LD]  = load_pin;
        pins[PIN_RB]  = readback_pin;
    end

    gw_sync #(.N(PIN_N), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .async_in(pins), .lvl(lvl)
    );

    assign edge_in = {lvl[PIN_RB], lvl[PIN_LD], ~lvl[PIN_SCK], lvl[PIN_SCK]};

    gw_edge #(.N(EDGE_N), .PREV_RST(EDGE_PREV_RST)) edge_i (
        .clk(clk), .rst(rst), .lvl(edge_in), .rise(rise)
    );

    assign sck_lvl  = lvl[PIN_SCK];
    assign sck_rise = rise[0];
    assign sck_fall = rise[1];
    assign ld_rise  = rise[2];
    assign rb_rise  = rise[3];

    gw_shift_latch #(.WORD_W(WORD_W)) sl_i (
        .clk(clk), .rst(rst),
        .sck_lvl(sck_lvl), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sid_lvl(lvl[PIN_SID]), .ld_rise(ld_rise), .rb_rise(rb_rise),
        .shift_word(shift_word), .latch_word(latch_word),
        .sod(sod), .proto_err(proto_err)
    );

    always_comb begin
        sel_word = serial_mode ? latch_word : par_word;
    end

    gw_gain_decode #(
        .FINE_W(FINE_W), .COARSE_W(COARSE_W), .COARSE_STEP(COARSE_STEP),
        .FINE_STEP(FINE_STEP), .GAIN_W(GAIN_W)
    ) dec_i (
        .word(sel_word), .gain_tenths(gain_tenths)
    );

    always_comb begin
        top_d    = top_q;
        top_d.pd = pwr_down;
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    assign pd_status = top_q.pd;
endmodule

// File: rtl/gainword_chk.sv
module gainword_chk #(
    parameter int WORD_W  = 9,
    parameter int GAIN_W  = 10,
    parameter int MAX_MAG = 240
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sck_lvl,
    input logic                     sck_fall,
    input logic                     ld_rise,
    input logic                     rb_rise,
    input logic [WORD_W-1:0]        shift_word,
    input logic [WORD_W-1:0]        latch_word,
    input logic                     sod,
    input logic                     proto_err,
    input logic [WORD_W-1:0]        sel_word,
    input logic signed [GAIN_W-1:0] gain_tenths
);
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_rise |=> latch_word == $past(latch_word)); // R4

    AST_BAD_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ld_rise && sck_lvl) |=> latch_word == $past(latch_word)); // R6

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(proto_err) |-> ($past(sck_lvl) && ($past(ld_rise) || $past(rb_rise)))); // R6

    AST_LOADBACK: assert property (@(posedge clk) disable iff (rst)
        (rb_rise && !sck_lvl) |=> (shift_word == $past(latch_word) && sod == $past(latch_word[0]))); // R5

    AST_SOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sck_fall && !rb_rise) |=> sod == $past(sod)); // R3

    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(gain_tenths) <= MAX_MAG && int'(gain_tenths) >= -MAX_MAG)); // R8

    AST_CUT_SIGN: assert property (@(posedge clk) disable iff (rst)
        sel_word[WORD_W-1] |-> gain_tenths <= 0); // R1

    AST_SWAP: assert property (@(posedge clk) disable iff (rst)
        (ld_rise && rb_rise && !sck_lvl) |=>
            (latch_word == $past(shift_word) && shift_word == $past(latch_word))); // R10
endmodule

bind gainword_ctrl gainword_chk #(
    .WORD_W (WORD_W),
    .GAIN_W (GAIN_W),
    .MAX_MAG((2**COARSE_W - 1) * COARSE_STEP + (2**FINE_W - 1) * FINE_STEP)
) chk_i (
    .clk(clk), .rst(rst), .sck_lvl(sck_lvl), .sck_fall(sck_fall),
    .ld_rise(ld_rise), .rb_rise(rb_rise), .shift_word(shift_word),
    .latch_word(latch_word), .sod(sod), .proto_err(proto_err),
    .sel_word(sel_word), .gain_tenths(gain_tenths)
);

// File: tb/gainword_ctrl_tb_top.sv
`timescale 1ns/1ps
module gainword_ctrl_tb_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sck_pin = 1'b0, sid_pin = 1'b0, load_pin = 1'b0, readback_pin = 1'b0;
    logic              serial_mode = 1'b1, pwr_down = 1'b0;
    logic [8:0]        par_word = '0;
    logic              sod, proto_err, pd_status;
    logic [8:0]        sel_word;
    logic signed [9:0] gain_tenths;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gainword_ctrl dut_i (
        .clk(clk), .rst(rst), .sck_pin(sck_pin), .sid_pin(sid_pin),
        .load_pin(load_pin), .readback_pin(readback_pin),
        .serial_mode(serial_mode), .pwr_down(pwr_down), .par_word(par_word),
        .sod(sod), .sel_word(sel_word), .gain_tenths(gain_tenths),
        .proto_err(proto_err), .pd_status(pd_status)
    );

    // parallel-mode vectors: word and expected gain (R1, R8)
    localparam int NV = 8;
    localparam logic [8:0] VEC_WORD [NV] = '{9'h000, 9'h100, 9'h0FF, 9'h1FF,
                                             9'h001, 9'h010, 9'h153, 9'h0A7};
    localparam int VEC_GAIN [NV] = '{0, 0, 240, -240, 1, 15, -78, 157};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_bit(input logic b);
        sid_pin = b; wclk(4);
        sck_pin = 1'b1; wclk(4);
        sck_pin = 1'b0; wclk(4);
    endtask

    task automatic shift_word(input logic [8:0] w);
        for (int i = 0; i < 9; i++) sck_bit(w[i]);
    endtask

    task automatic strobe(input logic ld, input logic rb);
        load_pin = ld; readback_pin = rb; wclk(4);
        load_pin = 1'b0; readback_pin = 1'b0; wclk(6);
    endtask

    // after a readback strobe, sod holds bit 0; collect the other bits
    task automatic read_rest(output logic [8:0] w);
        w[0] = sod;
        for (int i = 1; i < 9; i++) begin
            sck_bit(1'b0);
            w[i] = sod;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] rd;
        wclk(4);
        // R11 reset state
        chk("R11 reset sel", int'(sel_word), 0);
        chk("R11 reset gain", int'(gain_tenths), 0);
        chk("R11 reset sod", int'(sod), 0);
        chk("R11 reset err", int'(proto_err), 0);
        rst = 1'b0; wclk(4);

        // R2/R4: shift in, latch unchanged until load
        shift_word(9'h153);
        chk("R4 no load yet", int'(sel_word), 0);
        strobe(1'b1, 1'b0);
        chk("R2 serial word", int'(sel_word), 'h153);
        chk("R8 gain -78", int'(gain_tenths), -78);

        shift_word(9'h0A7);
        chk("R4 shift keeps active", int'(sel_word), 'h153);
        strobe(1'b1, 1'b0);
        chk("R4 new word", int'(sel_word), 'h0A7);
        chk("R8 gain 157", int'(gain_tenths), 157);

        // R6: load while sck high ignored
        shift_word(9'h1FF);
        sid_pin = 1'b1; wclk(4);
        sck_pin = 1'b1; wclk(4);
        load_pin = 1'b1; wclk(4);
        load_pin = 1'b0; wclk(4);
        sck_pin = 1'b0; wclk(4);
        chk("R6 bad load ignored", int'(sel_word), 'h0A7);
        chk("R6 err set", int'(proto_err), 1);
        strobe(1'b1, 1'b0);
        chk("R6 err cleared", int'(proto_err), 0);
        chk("R6 good load after", int'(sel_word), 'h1FF);
        chk("R8 gain -240", int'(gain_tenths), -240);

        // R5/R3: readback
        shift_word(9'h153);
        strobe(1'b1, 1'b0);
        shift_word(9'h000);
        strobe(1'b0, 1'b1);
        chk("R5 sod bit0 on readback", int'(sod), 1);
        read_rest(rd);
        chk("R3 readback word", int'(rd), 'h153);
        chk("R4 latch kept after readback", int'(sel_word), 'h153);

        // R10: simultaneous load and readback exchange
        shift_word(9'h02E);
        strobe(1'b1, 1'b1);
        chk("R10 latch took shift", int'(sel_word), 'h02E);
        chk("R10 gain 44", int'(gain_tenths), 44);
        chk("R10 sod old latch bit0", int'(sod), 1);
        read_rest(rd);
        chk("R10 shift took old latch", int'(rd), 'h153);

        // R9: powerdown
        pwr_down = 1'b1; wclk(2);
        chk("R9 pd status on", int'(pd_status), 1);
        chk("R9 latch kept in pd", int'(sel_word), 'h02E);
        shift_word(9'h0A7);
        strobe(1'b1, 1'b0);
        chk("R9 serial works in pd", int'(sel_word), 'h0A7);
        pwr_down = 1'b0; wclk(2);
        chk("R9 pd status off", int'(pd_status), 0);
        chk("R9 latch kept after pd", int'(sel_word), 'h0A7);

        // R7/R1/R8: parallel table
        serial_mode = 1'b0;
        for (int i = 0; i < NV; i++) begin
            par_word = VEC_WORD[i]; wclk(1);
            chk("R7 parallel sel", int'(sel_word), int'(VEC_WORD[i]));
            chk("R1 R8 parallel gain", int'(gain_tenths), VEC_GAIN[i]);
        end
        serial_mode = 1'b1; wclk(1);
        chk("R7 serial restored", int'(sel_word), 'h0A7);

        // R11: reset mid-run
        rst = 1'b1; wclk(3);
        chk("R11 reset clears latch", int'(sel_word), 0);
        chk("R11 reset gain", int'(gain_tenths), 0);
        chk("R11 reset sod", int'(sod), 0);
        rst = 1'b0; wclk(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule